// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit finds the operand of a single instruction under one of several addressing modes. A one-cycle start pulse presents four things: a mode code, a 16-bit address field A, a register number R and the current program counter. The unit captures all of them at once. It reads the register file through a combinational port and data memory through a read port with one cycle of latency. It then returns the operand value and the effective address (EA), and marks the result with a one-cycle done pulse.

Some modes need a chain of dependent memory reads: multilevel indirection, and the pre-index and post-index combinations. For these the unit issues the reads one after another, and each read address comes from the data of the previous read. Indexed mode can also write R+1 back to the index register. Each memory read takes two cycles: one to issue it and one to take its data. Done therefore rises 1 + 2·(number of reads) cycles after the clock edge that accepted start.

Top module: `operand_resolver`

## Requirements
- R1: Mode 0 (immediate) returns A as the operand and A as the EA. It performs no memory read.
- R2: Mode 1 (direct) uses EA = A and performs exactly one memory read, at A. The data returned is the operand.
- R3: Mode 2 (indirect) reads a pointer from A, then follows the chain. The number of pointer reads equals the depth input (1 to 3; a depth of 0 acts as 1). The last pointer is the EA, and one more read at the EA gives the operand.
- R4: Mode 3 (register) returns register R as the operand, with EA = R zero-extended. It performs no memory read.
- R5: Mode 4 (register indirect) uses EA = register R and performs one memory read.
- R6: Mode 5 (displacement) uses EA = A + register R. Mode 6 (relative) uses EA = A + PC. Each performs one read, and both sums wrap modulo 2^16.
- R7: Mode 7 (indexed) uses EA = A + register R and performs one read. When the auto-increment input is 1, register R is written with its old value + 1 (wrapping) in the cycle before done. No register is written in any other case.
- R8: Mode 8 (post-index) uses EA = mem[A] + register R. It performs two reads in total.
- R9: Mode 9 (pre-index) uses EA = mem[A + register R]. It performs two reads in total.
- R10: At most one memory read is in flight: the read strobe is never high on two adjacent cycles. Busy stays high from the accepting edge until done rises, and done rises exactly 1 + 2·reads cycles after that edge.
- R11: A start pulse that arrives while busy is high is ignored. The result, the reads and the timing of the current operation do not change.
- R12: Done is high for exactly one cycle. The operand and EA outputs change only in the cycle done rises, and they hold their values until the next result.
- R13: Mode codes 10 to 15 behave as immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request; accepted only when idle |
| mode_i | input | 4 | Addressing mode code |
| depth_i | input | 2 | Indirection level for mode 2 |
| autoinc_i | input | 1 | Increment the index register after an indexed access |
| a_i | input | 16 | Address field A |
| r_i | input | 3 | Register number R |
| pc_i | input | 16 | Current program counter |
| rf_addr_o | output | 3 | Register file address (read and write) |
| rf_rdata_i | input | 16 | Register file combinational read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | 16 | Register file write data |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after the strobe |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle result pulse |
| operand_o | output | 16 | Resolved operand |
| ea_o | output | 16 | Resolved effective address |

## Verification
The bench targets the following corner cases, and describes what a faulty design would do in each.
- Indirection depths 0 through 3: a design that miscounts levels returns the wrong EA and shows the wrong read count and done timing.
- Sums that cross 2^16 in displacement, relative and indexed modes, including an index register of 0xFFFF being incremented: these expose any carry into a wider result or a missing wrap.
- Pre-index and post-index run back to back: this catches a design that swaps where the register is added.
- A start pulse injected mid-chain: this catches a design that re-captures its inputs and corrupts the operation in flight.

// File: rtl/orsv_pkg.sv
package orsv_pkg;
    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] M_IMM    = 4'd0;
    localparam logic [MODE_W-1:0] M_DIR    = 4'd1;
    localparam logic [MODE_W-1:0] M_IND    = 4'd2;
    localparam logic [MODE_W-1:0] M_REG    = 4'd3;
    localparam logic [MODE_W-1:0] M_REGIND = 4'd4;
    localparam logic [MODE_W-1:0] M_DISP   = 4'd5;
    localparam logic [MODE_W-1:0] M_REL    = 4'd6;
    localparam logic [MODE_W-1:0] M_IDX    = 4'd7;
    localparam logic [MODE_W-1:0] M_POST   = 4'd8;
    localparam logic [MODE_W-1:0] M_PRE    = 4'd9;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CALC  = 2'd1,
        S_ISSUE = 2'd2,
        S_WAIT  = 2'd3
    } state_e;
endpackage

// File: rtl/orsv_plan.sv
module orsv_plan
    import orsv_pkg::*;
#(
    parameter int W    = 16,
    parameter int RW   = 3,
    parameter int DEPW = 2
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DEPW-1:0]   depth_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      pc_i,
    input  logic [RW-1:0]     rsel_i,
    input  logic [W-1:0]      rval_now_i,
    input  logic [W-1:0]      rval_held_i,
    input  logic [W-1:0]      ptr_data_i,
    output logic              need_read_o,
    output logic              first_ptr_o,
    output logic [DEPW-1:0]   levels_o,
    output logic [W-1:0]      first_addr_o,
    output logic [W-1:0]      nr_operand_o,
    output logic [W-1:0]      nr_ea_o,
    output logic [W-1:0]      link_ea_o
);
    localparam logic [DEPW-1:0] ONE_LVL = DEPW'(1);

    always_comb begin
        need_read_o  = 1'b1;
        first_ptr_o  = 1'b0;
        levels_o     = ONE_LVL;
        first_addr_o = a_i;
        nr_operand_o = a_i;
        nr_ea_o      = a_i;
        unique case (mode_i)
            M_DIR:    first_addr_o = a_i;
            M_IND: begin
                first_ptr_o = 1'b1;
                levels_o    = (depth_i == '0) ? ONE_LVL : depth_i;
            end
            M_REG: begin
                need_read_o  = 1'b0;
                nr_operand_o = rval_now_i;
                nr_ea_o      = W'(rsel_i);
            end
            M_REGIND: first_addr_o = rval_now_i;
            M_DISP, M_IDX: first_addr_o = a_i + rval_now_i;
            M_REL:    first_addr_o = a_i + pc_i;
            M_POST:   first_ptr_o  = 1'b1;
            M_PRE: begin
                first_ptr_o  = 1'b1;
                first_addr_o = a_i + rval_now_i;
            end
            default:  need_read_o = 1'b0;
        endcase
    end

    // After the last pointer read: post-index adds the held register value.
    always_comb begin
        link_ea_o = ptr_data_i;
        if (mode_i == M_POST) link_ea_o = ptr_data_i + rval_held_i;
    end
endmodule

// File: rtl/orsv_ctrl.sv
module orsv_ctrl
    import orsv_pkg::*;
#(
    parameter int W    = 16,
    parameter int RW   = 3,
    parameter int DEPW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DEPW-1:0]   depth_i,
    input  logic              autoinc_i,
    input  logic [W-1:0]      a_i,
    input  logic [RW-1:0]     r_i,
    input  logic [W-1:0]      pc_i,
    input  logic              need_read_i,
    input  logic              first_ptr_i,
    input  logic [DEPW-1:0]   levels_i,
    input  logic [W-1:0]      first_addr_i,
    input  logic [W-1:0]      nr_operand_i,
    input  logic [W-1:0]      nr_ea_i,
    input  logic [W-1:0]      link_ea_i,
    input  logic [W-1:0]      rf_rdata_i,
    input  logic [W-1:0]      mem_rdata_i,
    output logic [MODE_W-1:0] q_mode_o,
    output logic [DEPW-1:0]   q_depth_o,
    output logic [W-1:0]      q_a_o,
    output logic [W-1:0]      q_pc_o,
    output logic [RW-1:0]     q_rsel_o,
    output logic [W-1:0]      q_rval_o,
    output logic              rf_we_o,
    output logic [W-1:0]      rf_wdata_o,
    output logic              mem_re_o,
    output logic [W-1:0]      mem_addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [W-1:0]      operand_o,
    output logic [W-1:0]      ea_o
);
    localparam logic [DEPW-1:0] ONE_LVL = DEPW'(1);

    typedef struct packed {
        state_e            st;
        logic [MODE_W-1:0] mode;
        logic [DEPW-1:0]   depth;
        logic              autoinc;
        logic [W-1:0]      a;
        logic [W-1:0]      pc;
        logic [RW-1:0]     rsel;
        logic [W-1:0]      rval;
        logic [W-1:0]      addr;
        logic              ptr;
        logic [DEPW-1:0]   lvl;
        logic              done;
        logic [W-1:0]      operand;
        logic [W-1:0]      ea;
    } ctrl_s;

    ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        mem_re_o   = 1'b0;
        rf_we_o    = 1'b0;
        unique case (ctl_q.st)
            S_IDLE: begin
                if (start_i) begin
                    ctl_d.st      = S_CALC;
                    ctl_d.mode    = mode_i;
                    ctl_d.depth   = depth_i;
                    ctl_d.autoinc = autoinc_i;
                    ctl_d.a       = a_i;
                    ctl_d.pc      = pc_i;
                    ctl_d.rsel    = r_i;
                end
            end
            S_CALC: begin
                ctl_d.rval = rf_rdata_i;
                if (!need_read_i) begin
                    ctl_d.operand = nr_operand_i;
                    ctl_d.ea      = nr_ea_i;
                    ctl_d.done    = 1'b1;
                    ctl_d.st      = S_IDLE;
                end else begin
                    ctl_d.addr = first_addr_i;
                    ctl_d.ptr  = first_ptr_i;
                    ctl_d.lvl  = levels_i;
                    ctl_d.st   = S_ISSUE;
                end
            end
            S_ISSUE: begin
                mem_re_o = 1'b1;
                ctl_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (ctl_q.ptr) begin
                    if (ctl_q.lvl > ONE_LVL) begin
                        ctl_d.lvl  = ctl_q.lvl - ONE_LVL;
                        ctl_d.addr = mem_rdata_i;
                    end else begin
                        ctl_d.ptr  = 1'b0;
                        ctl_d.addr = link_ea_i;
                    end
                    ctl_d.st = S_ISSUE;
                end else begin
                    ctl_d.operand = mem_rdata_i;
                    ctl_d.ea      = ctl_q.addr;
                    ctl_d.done    = 1'b1;
                    ctl_d.st      = S_IDLE;
                    rf_we_o       = (ctl_q.mode == M_IDX) && ctl_q.autoinc;
                end
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= S_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign q_mode_o   = ctl_q.mode;
    assign q_depth_o  = ctl_q.depth;
    assign q_a_o      = ctl_q.a;
    assign q_pc_o     = ctl_q.pc;
    assign q_rsel_o   = ctl_q.rsel;
    assign q_rval_o   = ctl_q.rval;
    assign rf_wdata_o = ctl_q.rval + W'(1);
    assign mem_addr_o = ctl_q.addr;
    assign busy_o     = (ctl_q.st != S_IDLE);
    assign done_o     = ctl_q.done;
    assign operand_o  = ctl_q.operand;
    assign ea_o       = ctl_q.ea;

    // R1 / R4 / R13: a plan without reads finishes on the next edge with no strobe
    a_r1_no_read_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_CALC && !need_read_i) |=> (done_o && !mem_re_o));

    // R7: register writes only come from an auto-incrementing indexed access
    a_r7_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> (ctl_q.mode == M_IDX && ctl_q.autoinc && !ctl_q.ptr));

    a_r10_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re_o |=> !mem_re_o);

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (ctl_q.a == $past(ctl_q.a) && ctl_q.mode == $past(ctl_q.mode)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(operand_o) || !$stable(ea_o)) |-> done_o);
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import orsv_pkg::*;
#(
    parameter int W         = 16,
    parameter int NREGS     = 8,
    parameter int MAX_DEPTH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [3:0]               mode_i,
    input  logic [$clog2(MAX_DEPTH+1)-1:0] depth_i,
    input  logic                     autoinc_i,
    input  logic [W-1:0]             a_i,
    input  logic [$clog2(NREGS)-1:0] r_i,
    input  logic [W-1:0]             pc_i,
    output logic [$clog2(NREGS)-1:0] rf_addr_o,
    input  logic [W-1:0]             rf_rdata_i,
    output logic                     rf_we_o,
    output logic [W-1:0]             rf_wdata_o,
    output logic                     mem_re_o,
    output logic [W-1:0]             mem_addr_o,
    input  logic [W-1:0]             mem_rdata_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [W-1:0]             operand_o,
    output logic [W-1:0]             ea_o
);
    localparam int RW   = $clog2(NREGS);
    localparam int DEPW = $clog2(MAX_DEPTH+1);

    logic [MODE_W-1:0] q_mode;
    logic [DEPW-1:0]   q_depth;
    logic [W-1:0]      q_a, q_pc, q_rval;
    logic [RW-1:0]     q_rsel;
    logic              need_read, first_ptr;
    logic [DEPW-1:0]   levels;
    logic [W-1:0]      first_addr, nr_operand, nr_ea, link_ea;

    orsv_plan #(.W(W), .RW(RW), .DEPW(DEPW)) u_plan (
        .mode_i       (q_mode),
        .depth_i      (q_depth),
        .a_i          (q_a),
        .pc_i         (q_pc),
        .rsel_i       (q_rsel),
        .rval_now_i   (rf_rdata_i),
        .rval_held_i  (q_rval),
        .ptr_data_i   (mem_rdata_i),
        .need_read_o  (need_read),
        .first_ptr_o  (first_ptr),
        .levels_o     (levels),
        .first_addr_o (first_addr),
        .nr_operand_o (nr_operand),
        .nr_ea_o      (nr_ea),
        .link_ea_o    (link_ea)
    );

    orsv_ctrl #(.W(W), .RW(RW), .DEPW(DEPW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mode_i       (mode_i),
        .depth_i      (depth_i),
        .autoinc_i    (autoinc_i),
        .a_i          (a_i),
        .r_i          (r_i),
        .pc_i         (pc_i),
        .need_read_i  (need_read),
        .first_ptr_i  (first_ptr),
        .levels_i     (levels),
        .first_addr_i (first_addr),
        .nr_operand_i (nr_operand),
        .nr_ea_i      (nr_ea),
        .link_ea_i    (link_ea),
        .rf_rdata_i   (rf_rdata_i),
        .mem_rdata_i  (mem_rdata_i),
        .q_mode_o     (q_mode),
        .q_depth_o    (q_depth),
        .q_a_o        (q_a),
        .q_pc_o       (q_pc),
        .q_rsel_o     (q_rsel),
        .q_rval_o     (q_rval),
        .rf_we_o      (rf_we_o),
        .rf_wdata_o   (rf_wdata_o),
        .mem_re_o     (mem_re_o),
        .mem_addr_o   (mem_addr_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .operand_o    (operand_o),
        .ea_o         (ea_o)
    );

    assign rf_addr_o = q_rsel;
endmodule

// File: tb/operand_resolver_tb.sv
`timescale 1ns/1ps
module operand_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [1:0]  depth_i = '0;
    logic        autoinc_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [2:0]  r_i = '0;
    logic [15:0] pc_i = '0;
    logic [2:0]  rf_addr_o;
    logic [15:0] rf_rdata_i;
    logic        rf_we_o;
    logic [15:0] rf_wdata_o;
    logic        mem_re_o;
    logic [15:0] mem_addr_o;
    logic [15:0] mem_rdata_i = '0;
    logic        busy_o, done_o;
    logic [15:0] operand_o, ea_o;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int b2b_hits = 0;
    int cyc = 0;
    bit finished = 0;
    logic prev_re = 1'b0;

    logic [15:0] rf_m [8];
    logic [15:0] exp_rf [8];
    logic [15:0] mem_ov [int];

    always #2.5 clk = ~clk;

    operand_resolver u_dut (.*);

    function automatic logic [15:0] memval(logic [15:0] ad);
        if (mem_ov.exists(int'(ad))) return mem_ov[int'(ad)];
        return ad * 16'd7 + 16'h0101;
    endfunction

    assign rf_rdata_i = rf_m[rf_addr_o];

    always @(posedge clk) begin
        if (mem_re_o) mem_rdata_i <= memval(mem_addr_o);
        if (rf_we_o) rf_m[rf_addr_o] <= rf_wdata_o;
        if (mem_re_o) rd_cnt++;
        if (mem_re_o && prev_re) b2b_hits++;
        prev_re <= mem_re_o;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            tests++; fails++;
            $display("FAIL watchdog R10: actual no completion expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(string tag, logic [3:0] m, logic [1:0] d, logic ai,
                          logic [15:0] a, logic [2:0] r, logic [15:0] pc, bit inject);
        logic [15:0] ea, op, p;
        int reads, n, dd;
        ea = a; op = a; reads = 0;
        case (m)
            4'd1: begin ea = a; reads = 1; end
            4'd2: begin
                dd = (d == 0) ? 1 : int'(d);
                p = a;
                for (int i = 0; i < dd; i++) p = memval(p);
                ea = p; reads = dd + 1;
            end
            4'd3: begin op = rf_m[r]; ea = {13'b0, r}; end
            4'd4: begin ea = rf_m[r]; reads = 1; end
            4'd5, 4'd7: begin ea = a + rf_m[r]; reads = 1; end
            4'd6: begin ea = a + pc; reads = 1; end
            4'd8: begin ea = memval(a) + rf_m[r]; reads = 2; end
            4'd9: begin ea = memval(a + rf_m[r]); reads = 2; end
            default: begin op = a; ea = a; end
        endcase
        if (reads > 0) op = memval(ea);
        for (int i = 0; i < 8; i++) exp_rf[i] = rf_m[i];
        if (m == 4'd7 && ai) exp_rf[r] = rf_m[r] + 16'd1;
        n = 1 + 2 * reads;

        @(negedge clk);
        mode_i = m; depth_i = d; autoinc_i = ai; a_i = a; r_i = r; pc_i = pc;
        start_i = 1'b1; rd_cnt = 0;
        @(negedge clk);
        start_i = 1'b0;
        check(tag, "busy after accept (R10)", {15'b0, busy_o}, 16'd1);
        for (int k = 1; k <= n + 1; k++) begin
            if (inject && k == 1) begin
                start_i = 1'b1; mode_i = 4'd0; a_i = 16'hDEAD; r_i = 3'd0; autoinc_i = 1'b1;
            end
            @(negedge clk);
            start_i = 1'b0;
            check(tag, $sformatf("done at cycle %0d (R12)", k), {15'b0, done_o}, {15'b0, k == n});
            check(tag, $sformatf("busy at cycle %0d (R10)", k), {15'b0, busy_o}, {15'b0, k < n});
            if (k == n) begin
                check(tag, "operand", operand_o, op);
                check(tag, "ea", ea_o, ea);
            end
        end
        check(tag, "operand held (R12)", operand_o, op);
        check(tag, "ea held (R12)", ea_o, ea);
        check(tag, "read count (R10)", 16'(rd_cnt), 16'(reads));
        for (int i = 0; i < 8; i++)
            check(tag, $sformatf("reg %0d", i), rf_m[i], exp_rf[i]);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) rf_m[i] = 16'h1000 * 16'(i) + 16'h0011;
        rf_m[2] = 16'h0020;
        rf_m[6] = 16'hFFFF;
        mem_ov[16'h0040] = 16'h0100;
        mem_ov[16'h0100] = 16'h0200;
        mem_ov[16'h0200] = 16'h0300;
        repeat (3) @(negedge clk);
        check("R12", "reset done", {15'b0, done_o}, 16'd0);
        check("R10", "reset busy", {15'b0, busy_o}, 16'd0);
        check("R10", "reset mem_re", {15'b0, mem_re_o}, 16'd0);
        check("R12", "reset operand", operand_o, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R1",  4'd0, 2'd0, 1'b0, 16'h1234, 3'd1, 16'h0000, 0);
        run_op("R13", 4'd12, 2'd0, 1'b0, 16'hBEEF, 3'd1, 16'h0000, 0);
        run_op("R13", 4'd15, 2'd3, 1'b1, 16'h0007, 3'd6, 16'h0000, 0);
        run_op("R2",  4'd1, 2'd0, 1'b0, 16'h0040, 3'd1, 16'h0000, 0);
        run_op("R3",  4'd2, 2'd1, 1'b0, 16'h0040, 3'd1, 16'h0000, 0);
        run_op("R3",  4'd2, 2'd2, 1'b0, 16'h0040, 3'd1, 16'h0000, 0);
        run_op("R3",  4'd2, 2'd3, 1'b0, 16'h0040, 3'd1, 16'h0000, 0);
        run_op("R3",  4'd2, 2'd0, 1'b0, 16'h0040, 3'd1, 16'h0000, 0);
        run_op("R4",  4'd3, 2'd0, 1'b0, 16'h0000, 3'd5, 16'h0000, 0);
        run_op("R5",  4'd4, 2'd0, 1'b0, 16'h0000, 3'd3, 16'h0000, 0);
        run_op("R6",  4'd5, 2'd0, 1'b0, 16'hFFF0, 3'd2, 16'h0000, 0);
        run_op("R6",  4'd6, 2'd0, 1'b0, 16'h0200, 3'd0, 16'hFF00, 0);
        run_op("R7",  4'd7, 2'd0, 1'b1, 16'h0010, 3'd6, 16'h0000, 0);
        run_op("R7",  4'd7, 2'd0, 1'b1, 16'h0010, 3'd6, 16'h0000, 0);
        run_op("R7",  4'd7, 2'd0, 1'b0, 16'h0030, 3'd2, 16'h0000, 0);
        run_op("R8",  4'd8, 2'd0, 1'b0, 16'h0040, 3'd2, 16'h0000, 0);
        run_op("R9",  4'd9, 2'd0, 1'b0, 16'h0020, 3'd2, 16'h0000, 0);
        run_op("R11", 4'd2, 2'd3, 1'b0, 16'h0040, 3'd1, 16'h0000, 1);
        run_op("R11", 4'd5, 2'd0, 1'b0, 16'h0100, 3'd2, 16'h0000, 1);

        check("R10", "back-to-back read strobes", 16'(b2b_hits), 16'd0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule